// File: doc/BRIEF.md
# Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers behind one write port and two read ports. The write port can update a register at 64, 32, 16 or 8 bits. A narrow write is merged into the stored word. A 32-bit write clears the upper half of the register. A 16-bit or 8-bit write leaves every bit outside its field as it was. Registers 0 to 3 also have a second byte view that covers bits 15:8. A separate paired write port loads two fixed registers in one cycle, so that a double-width result can be retired in a single step.

Each read port picks a register, a width and an extension mode. The selected field is returned on a 64-bit bus, either zero-extended or sign-extended. Reads are combinational from the stored state.

Top module: `pw_regfile`

## Requirements
- R1: After reset every register reads as zero on both ports.
- R2: A write with width code 2'b11 replaces all 64 bits of the addressed register.
- R3: A write with width code 2'b10 stores data bits 31:0 into register bits 31:0 and sets bits 63:32 to zero.
- R4: A write with width code 2'b01 stores data bits 15:0 into register bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with width code 2'b00 and the high-byte flag clear stores data bits 7:0 into register bits 7:0 and leaves all other bits unchanged.
- R6: A write with width code 2'b00 and the high-byte flag set, to register 0, 1, 2 or 3, stores data bits 7:0 into register bits 15:8 and leaves all other bits unchanged. A read of the same kind returns bits 15:8. The high-byte flag has no effect with any other width code.
- R7: A high-byte write (width 2'b00, flag set) to register 4 or above changes no register. A high-byte read of such a register returns zero.
- R8: With the extend select low, a read returns the selected field (8, 16, 32 or 64 bits for width codes 2'b00 to 2'b11) with all higher bits zero.
- R9: With the extend select high, a read returns the selected field with bit 63 down to the bit just above the field copied from the top bit of the field.
- R10: When the pair enable is high, register 2 takes the high word and register 0 takes the low word at the same clock edge. Any single write in that cycle is dropped.
- R11: A read of a register that is written in the same cycle returns the value held before that write.
- R12: The two read ports select register, width, high-byte view and extension independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single write enable |
| wr_idx | input | 4 | Register written |
| wr_size | input | 2 | Write width code (00=8, 01=16, 10=32, 11=64) |
| wr_hi | input | 1 | Write targets bits 15:8 (8-bit width only) |
| wr_data | input | 64 | Write data, right-aligned |
| pair_en | input | 1 | Paired double-width write enable |
| pair_hi | input | 64 | Upper word, stored in register 2 |
| pair_lo | input | 64 | Lower word, stored in register 0 |
| rd0_idx | input | 4 | Read port 0 register |
| rd0_size | input | 2 | Read port 0 width code |
| rd0_hi | input | 1 | Read port 0 takes bits 15:8 |
| rd0_sext | input | 1 | Read port 0 sign-extends when high |
| rd0_data | output | 64 | Read port 0 result |
| rd1_idx | input | 4 | Read port 1 register |
| rd1_size | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 takes bits 15:8 |
| rd1_sext | input | 1 | Read port 1 sign-extends when high |
| rd1_data | output | 64 | Read port 1 result |

## Verification
The hardest case to observe is a merge that keeps bits which no earlier step has made distinct. If a register still holds zeros, a write that wrongly clears the upper bits looks correct. The stimulus therefore fills each target register with a full 64-bit pattern before every narrow write. It then reads the register back at full width, so that every preserved or cleared bit is visible.

A second case is a paired write that coincides with a single write. The stimulus drives both in the same cycle and then reads back the registers of both writes.

A long run of mixed random writes and reads follows. It is compared on every cycle against a behavioural model, which also covers the reads of a register in the same cycle it is written.

// File: rtl/pw_regfile.sv
module pw_regfile #(
  parameter int NREG     = 16,
  parameter int HI_REGS  = 4,
  parameter int PAIR_HI  = 2,
  parameter int PAIR_LO  = 0,
  localparam int AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [1:0]    wr_size,
  input  logic          wr_hi,
  input  logic [63:0]   wr_data,
  input  logic          pair_en,
  input  logic [63:0]   pair_hi,
  input  logic [63:0]   pair_lo,
  input  logic [AW-1:0] rd0_idx,
  input  logic [1:0]    rd0_size,
  input  logic          rd0_hi,
  input  logic          rd0_sext,
  output logic [63:0]   rd0_data,
  input  logic [AW-1:0] rd1_idx,
  input  logic [1:0]    rd1_size,
  input  logic          rd1_hi,
  input  logic          rd1_sext,
  output logic [63:0]   rd1_data
);
  localparam logic [AW-1:0] HI_LIM = AW'(HI_REGS);

  logic [63:0] regs [NREG];
  logic [63:0] merged;
  logic        wr_hibyte, wr_go;

  assign wr_hibyte = wr_hi && (wr_size == 2'b00);
  assign wr_go     = wr_en && !pair_en && !(wr_hibyte && wr_idx >= HI_LIM);

  always_comb begin
    merged = regs[wr_idx];
    case (wr_size)
      2'b00: if (wr_hibyte) merged[15:8] = wr_data[7:0];
             else           merged[7:0]  = wr_data[7:0];
      2'b01: merged[15:0] = wr_data[15:0];
      2'b10: merged = {32'd0, wr_data[31:0]};
      default: merged = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (pair_en) begin
      regs[PAIR_HI] <= pair_hi;
      regs[PAIR_LO] <= pair_lo;
    end else if (wr_go) begin
      regs[wr_idx] <= merged;
    end
  end

  function automatic logic [63:0] fetch(input logic [63:0] w, input logic [AW-1:0] idx,
                                        input logic [1:0] sz, input logic hi, input logic sx);
    logic [63:0] r;
    case (sz)
      2'b00: begin
        if (hi) r = (idx < HI_LIM) ? {{56{sx & w[15]}}, w[15:8]} : 64'd0;
        else    r = {{56{sx & w[7]}}, w[7:0]};
      end
      2'b01:   r = {{48{sx & w[15]}}, w[15:0]};
      2'b10:   r = {{32{sx & w[31]}}, w[31:0]};
      default: r = w;
    endcase
    return r;
  endfunction

  assign rd0_data = fetch(regs[rd0_idx], rd0_idx, rd0_size, rd0_hi, rd0_sext);
  assign rd1_data = fetch(regs[rd1_idx], rd1_idx, rd1_size, rd1_hi, rd1_sext);
endmodule

// File: rtl/pw_regfile_chk.sv
module pw_regfile_chk #(
  parameter int NREG    = 16,
  parameter int HI_REGS = 4,
  parameter int PAIR_HI = 2,
  parameter int PAIR_LO = 0,
  localparam int AW     = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_idx,
  input logic [1:0]    wr_size,
  input logic          wr_hi,
  input logic [63:0]   wr_data,
  input logic          pair_en,
  input logic [63:0]   pair_hi,
  input logic [63:0]   pair_lo,
  input logic [63:0]   regs [NREG]
);
  localparam logic [AW-1:0] HI_LIM = AW'(HI_REGS);
  logic single;
  assign single = wr_en && !pair_en;

  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (single && wr_size == 2'b10) |=> regs[$past(wr_idx)] == {32'd0, $past(wr_data[31:0])});

  a_r4_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (single && wr_size == 2'b01) |=>
      regs[$past(wr_idx)] == {$past(regs[wr_idx][63:16]), $past(wr_data[15:0])});

  a_r6_hi_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (single && wr_size == 2'b00 && wr_hi && wr_idx < HI_LIM) |=>
      regs[$past(wr_idx)] == {$past(regs[wr_idx][63:16]), $past(wr_data[7:0]), $past(regs[wr_idx][7:0])});

  a_r7_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (single && wr_size == 2'b00 && wr_hi && wr_idx >= HI_LIM) |=>
      regs[$past(wr_idx)] == $past(regs[wr_idx]));

  a_r10_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pair_en |=> (regs[PAIR_HI] == $past(pair_hi)) && (regs[PAIR_LO] == $past(pair_lo)));
endmodule

bind pw_regfile pw_regfile_chk #(.NREG(NREG), .HI_REGS(HI_REGS), .PAIR_HI(PAIR_HI), .PAIR_LO(PAIR_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
  .wr_data(wr_data), .pair_en(pair_en), .pair_hi(pair_hi), .pair_lo(pair_lo), .regs(regs)
);

// File: tb/sim_pw_regfile.sv
module sim_pw_regfile;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_hi = 0, pair_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [1:0]  wr_size = 0;
  logic [63:0] wr_data = 0, pair_hi = 0, pair_lo = 0;
  logic [3:0]  rd0_idx = 0, rd1_idx = 0;
  logic [1:0]  rd0_size = 3, rd1_size = 3;
  logic        rd0_hi = 0, rd1_hi = 0, rd0_sext = 0, rd1_sext = 0;
  logic [63:0] rd0_data, rd1_data;

  pw_regfile u0 (.*);

  logic [63:0] mdl [16];
  int checks = 0, errors = 0;

  function automatic logic [63:0] ref_read(int idx, logic [1:0] sz, logic hi, logic sx);
    logic [63:0] w, f;
    int bits;
    w = mdl[idx];
    bits = 8 << sz;
    if (sz == 2'b00 && hi) begin
      if (idx > 3) return 64'd0;
      f = (w >> 8) & 64'hFF;
    end else if (bits == 64) f = w;
    else f = w & ((64'd1 << bits) - 64'd1);
    if (sx && bits < 64 && f[bits-1]) f = f - (64'd1 << bits);
    return f;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    #1;
    chk(tag, rd0_data, ref_read(rd0_idx, rd0_size, rd0_hi, rd0_sext));
    chk(tag, rd1_data, ref_read(rd1_idx, rd1_size, rd1_hi, rd1_sext));
    @(posedge clk);
    if (pair_en) begin
      mdl[2] = pair_hi;
      mdl[0] = pair_lo;
    end else if (wr_en) begin
      case (wr_size)
        2'b11: mdl[wr_idx] = wr_data;
        2'b10: mdl[wr_idx] = wr_data & 64'hFFFF_FFFF;
        2'b01: mdl[wr_idx] = (mdl[wr_idx] & ~64'hFFFF) | (wr_data & 64'hFFFF);
        default:
          if (!wr_hi) mdl[wr_idx] = (mdl[wr_idx] & ~64'hFF) | (wr_data & 64'hFF);
          else if (wr_idx < 4) mdl[wr_idx] = (mdl[wr_idx] & ~64'hFF00) | ((wr_data & 64'hFF) << 8);
      endcase
    end
    @(negedge clk);
    wr_en = 0; pair_en = 0; wr_hi = 0;
  endtask

  task automatic wr(int idx, logic [1:0] sz, logic hi, logic [63:0] d, string tag);
    wr_en = 1; wr_idx = 4'(idx); wr_size = sz; wr_hi = hi; wr_data = d;
    tick(tag);
  endtask

  task automatic rd(int a, logic [1:0] sa, logic ha, logic xa,
                    int b, logic [1:0] sb, logic hb, logic xb, string tag);
    rd0_idx = 4'(a); rd0_size = sa; rd0_hi = ha; rd0_sext = xa;
    rd1_idx = 4'(b); rd1_size = sb; rd1_hi = hb; rd1_sext = xb;
    tick(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 64'd0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) rd(i, 3, 0, 0, 15 - i, 3, 0, 0, "R1");

    wr(5, 3, 0, 64'hDEAD_BEEF_0123_4567, "R2");
    rd(5, 3, 0, 0, 5, 3, 0, 0, "R2");
    wr(5, 2, 0, 64'hFFFF_FFFF_8765_4321, "R3");
    rd(5, 3, 0, 0, 5, 2, 0, 0, "R3");
    wr(7, 3, 0, 64'hA5A5_5A5A_C3C3_3C3C, "R4");
    wr(7, 1, 0, 64'hFFFF_FFFF_FFFF_1234, "R4");
    rd(7, 3, 0, 0, 7, 1, 0, 0, "R4");
    wr(9, 3, 0, 64'h1122_3344_5566_7788, "R5");
    wr(9, 0, 0, 64'hFFFF_FFFF_FFFF_FF9A, "R5");
    rd(9, 3, 0, 0, 9, 0, 0, 0, "R5");
    wr(3, 3, 0, 64'h0102_0304_0506_0708, "R6");
    wr(3, 0, 1, 64'h0000_0000_0000_00EE, "R6");
    rd(3, 3, 0, 0, 3, 0, 1, 0, "R6");
    wr(1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    wr(1, 1, 1, 64'h0000_0000_0000_4321, "R6");
    rd(1, 3, 0, 0, 1, 0, 1, 1, "R6");
    wr(9, 0, 1, 64'h0000_0000_0000_0077, "R7");
    rd(9, 3, 0, 0, 9, 0, 1, 0, "R7");
    wr(12, 3, 0, 64'h8000_0000_8000_8080, "R8");
    rd(12, 0, 0, 0, 12, 0, 0, 1, "R9");
    rd(12, 1, 0, 0, 12, 1, 0, 1, "R9");
    rd(12, 2, 0, 0, 12, 2, 0, 1, "R8");
    rd(12, 3, 0, 1, 12, 0, 1, 1, "R8");
    wr(0, 3, 0, 64'h5555_5555_5555_5555, "R10");
    wr(4, 3, 0, 64'h4444_4444_4444_4444, "R10");
    pair_en = 1; pair_hi = 64'hFEDC_BA98_7654_3210; pair_lo = 64'h0F1E_2D3C_4B5A_6978;
    wr_en = 1; wr_idx = 4; wr_size = 3; wr_data = 64'h0;
    tick("R10");
    rd(2, 3, 0, 0, 0, 3, 0, 0, "R10");
    rd(4, 3, 0, 0, 4, 3, 0, 0, "R10");
    rd0_idx = 5; rd0_size = 3; rd1_idx = 5; rd1_size = 2;
    wr(5, 3, 0, 64'hCAFE_F00D_1234_5678, "R11");
    rd(5, 3, 0, 0, 7, 1, 0, 1, "R11");
    rd(3, 0, 1, 1, 12, 2, 0, 0, "R12");

    for (int n = 0; n < 400; n++) begin
      rd0_idx = 4'($urandom); rd0_size = 2'($urandom); rd0_hi = 1'($urandom); rd0_sext = 1'($urandom);
      rd1_idx = 4'($urandom); rd1_size = 2'($urandom); rd1_hi = 1'($urandom); rd1_sext = 1'($urandom);
      pair_en = ($urandom % 16) == 0;
      pair_hi = {$urandom, $urandom}; pair_lo = {$urandom, $urandom};
      wr_en = 1'($urandom); wr_idx = ($urandom % 2) ? 4'($urandom % 4) : 4'($urandom);
      wr_size = 2'($urandom); wr_hi = 1'($urandom);
      wr_data = {$urandom, $urandom};
      tick("R12");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule